// File: doc/BRIEF.md
# Multi-Master Bus Matrix Arbiter

This block sits between a set of bus masters and a set of slave ports and decides, every clock, which master owns each slave. Each master presents a request, an address and a burst-continue flag. A decoder for each master turns the top bits of its address into a target slave, or flags the address as unmapped. Each slave port has its own arbiter. The arbiter keeps a registered owner and hands the port to contending masters in round-robin order. A master in the middle of a burst keeps the port until it stops or until a programmable slot budget for that port runs out.

When a slave port has no requests, it parks. Depending on a per-port mode it parks on nobody, on its most recent owner, or on a configured master. A parked master that then requests is served in the same cycle, with no arbitration cycle. The block carries only a thin write-data multiplexer per slave. Bus protocol details, wait states and error responses are left to the surrounding fabric.

Top module: `busmx_arbiter`

## Requirements
- R1: Address bits [AW-1:AW-SEL_W] (bits 15:13 by default) give the target slave index. A master with a request and a mapped code raises the grant bit for itself only at that slave (bit s*N_MST+m of s_gnt).
- R2: Codes at or above N_SLV (6 and 7 by default) are unmapped. A requesting master with such a code has m_dec_err high in the same cycle, m_ready low, and takes no part in any slave's arbitration.
- R3: Every slave's grant field is one-hot or all zero in every cycle. After reset all grants and all m_ready bits are zero.
- R4: The grant is registered. A requesting master that does not own its target slave is granted from the next clock edge on, provided it wins arbitration. m_ready[m] is high when m requests and holds the grant at the slave it addresses.
- R5: When a slave is re-arbitrated, the winner is the first requester at or after that slave's pointer, counting upward and wrapping. The pointer then moves to one past the winner. Pointers start at 0.
- R6: Park mode 0 (cfg_park_mode field value 0, and also value 3): a slave with no request grants nobody from the next edge on.
- R7: Park mode 1: a slave with no request keeps the grant with its current owner.
- R8: Park mode 2: a slave with no request grants the master given by its cfg_park_mst field. If the index is N_MST or above, it grants nobody.
- R9: A master that holds a parked grant and starts requesting that slave sees m_ready high in the same cycle.
- R10: An owner that keeps requesting with m_burst high keeps the port. This holds for as long as the slot limit is 0, or while no other master requests that slave.
- R11: With a slot limit L above 0 and another requester present, a bursting owner gets exactly L ready cycles. After that the port is re-arbitrated, with the pointer past the owner. The budget is reloaded to L whenever a grant is taken or parked.
- R12: An owner with m_burst low is re-arbitrated at every edge, so that other requesters take turns.
- R13: s_wdata for each slave carries the write data of the master granted there, and is zero when nobody is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | N_MST (6) | Per-master access request |
| m_addr | input | N_MST*AW (96) | Per-master address, master m at bits m*AW |
| m_burst | input | N_MST (6) | Per-master flag: burst continues, keep the port |
| m_wdata | input | N_MST*DW (48) | Per-master write data |
| cfg_park_mode | input | 2*N_SLV (12) | Per-slave park mode: 0 none, 1 last owner, 2 fixed, 3 none |
| cfg_park_mst | input | MIDX_W*N_SLV (18) | Per-slave fixed park master index |
| cfg_slot_lim | input | LIM_W*N_SLV (24) | Per-slave slot cycle limit, 0 disables burst breaking |
| s_gnt | output | N_SLV*N_MST (36) | Per-slave grant vectors, slave s at bits s*N_MST |
| s_wdata | output | N_SLV*DW (48) | Per-slave write data from the granted master |
| m_ready | output | N_MST (6) | Per-master: request accepted this cycle |
| m_dec_err | output | N_MST (6) | Per-master: requesting with an unmapped address |

## Verification
The assertions take the master inputs and the configuration fields as stable across each rising edge and free of unknown values. They place no other limits on them: requests may appear, move between slaves or drop in any cycle, and the park mode, park index and slot limit may change at any time. The stimulus drives every input on the falling edge, so each value is settled a half period before the edge that samples it. Directed sequences cover each park mode, the slot budget with and without contention, and unmapped codes. A long random phase then changes the addresses every cycle and the configuration every hundred cycles, with all values inside the declared field widths.

// File: rtl/busmx_pkg.sv
package busmx_pkg;

   // Park behaviour of an idle slave port (2-bit configuration field)
   typedef enum logic [1:0] {
      PARK_NONE     = 2'd0,
      PARK_LAST     = 2'd1,
      PARK_FIXED    = 2'd2,
      PARK_NONE_ALT = 2'd3
   } park_mode_e;

   // Index width for a count of n items, at least one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/busmx_decoder.sv
module busmx_decoder #(
   parameter int unsigned AW    = 16,
   parameter int unsigned SEL_W = 3,
   parameter int unsigned N_SLV = 6
) (
   input  logic             req,
   input  logic [AW-1:0]    addr,
   output logic [N_SLV-1:0] sel,
   output logic             err
);

   localparam int unsigned CODES = 1 << SEL_W;

   initial begin
      assert (SEL_W >= 1 && SEL_W <= AW)
         else $error("busmx_decoder: SEL_W must lie in 1..AW");
      assert (N_SLV >= 1 && N_SLV <= CODES)
         else $error("busmx_decoder: N_SLV exceeds the code space");
   end

   logic [SEL_W-1:0] code;
   assign code = addr[AW-1 -: SEL_W];

   always_comb begin
      sel = '0;
      for (int s = 0; s < N_SLV; s++) begin
         if (req && (code == SEL_W'(s))) sel[s] = 1'b1;
      end
   end

   // A full code space has no hole; otherwise codes past the last slave are unmapped
   generate
      if (N_SLV == CODES) begin : g_full_map
         assign err = 1'b0;
      end else begin : g_part_map
         assign err = req && (32'(code) >= N_SLV);
      end
   endgenerate

endmodule

// File: rtl/busmx_port_arb.sv
module busmx_port_arb
   import busmx_pkg::*;
#(
   parameter int unsigned N_MST  = 6,
   parameter int unsigned LIM_W  = 4,
   parameter int unsigned MIDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_MST-1:0]  req,
   input  logic [N_MST-1:0]  burst,
   input  logic [1:0]        park_mode,
   input  logic [MIDX_W-1:0] park_mst,
   input  logic [LIM_W-1:0]  slot_lim,
   output logic [N_MST-1:0]  gnt
);

   localparam logic [MIDX_W:0]   MCNT = (MIDX_W+1)'(N_MST);
   localparam logic [MIDX_W-1:0] MLST = MIDX_W'(N_MST - 1);

   initial begin
      assert (N_MST >= 1 && MIDX_W >= idx_w(N_MST))
         else $error("busmx_port_arb: MIDX_W too narrow for N_MST");
      assert (LIM_W >= 1)
         else $error("busmx_port_arb: LIM_W must be at least 1");
   end

   // Registered ownership state
   logic              own_vld, nxt_vld;
   logic [MIDX_W-1:0] own_idx, nxt_idx;
   logic [MIDX_W-1:0] ptr, nxt_ptr;
   logic [LIM_W-1:0]  cnt, nxt_cnt;

   logic [N_MST-1:0]  own_oh;
   logic              others, expired, hold;
   logic [MIDX_W-1:0] pick;

   always_comb begin
      own_oh = '0;
      if (own_vld) own_oh[own_idx] = 1'b1;
   end

   assign others  = |(req & ~own_oh);
   assign expired = (slot_lim != '0) && (cnt <= LIM_W'(1));
   assign hold    = own_vld && req[own_idx] && burst[own_idx] && !(expired && others);

   // Round-robin search starting at the pointer
   always_comb begin
      logic found;
      int   c;
      pick  = '0;
      found = 1'b0;
      for (int k = 0; k < N_MST; k++) begin
         c = int'(ptr) + k;
         if (c >= N_MST) c = c - N_MST;
         if (!found && req[c]) begin
            found = 1'b1;
            pick  = c[MIDX_W-1:0];
         end
      end
   end

   always_comb begin
      nxt_vld = own_vld;
      nxt_idx = own_idx;
      nxt_ptr = ptr;
      nxt_cnt = slot_lim;
      if (hold) begin
         nxt_cnt = (cnt == '0) ? '0 : cnt - 1'b1;
      end else if (|req) begin
         nxt_vld = 1'b1;
         nxt_idx = pick;
         nxt_ptr = (pick == MLST) ? '0 : pick + 1'b1;
      end else begin
         unique case (park_mode_e'(park_mode))
            PARK_LAST: begin
               nxt_vld = own_vld;
               nxt_idx = own_idx;
            end
            PARK_FIXED: begin
               nxt_vld = ({1'b0, park_mst} < MCNT);
               nxt_idx = ({1'b0, park_mst} < MCNT) ? park_mst : '0;
            end
            default: begin
               nxt_vld = 1'b0;
               nxt_idx = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_vld <= 1'b0;
         own_idx <= '0;
         ptr     <= '0;
         cnt     <= '0;
      end else begin
         own_vld <= nxt_vld;
         own_idx <= nxt_idx;
         ptr     <= nxt_ptr;
         cnt     <= nxt_cnt;
      end
   end

   assign gnt = own_oh;

   // R3: at most one owner per port
   a_r3_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R4: any request this cycle leaves the port owned next cycle
   a_r4_busy_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> (|gnt));

   // R10: an uncontended bursting owner keeps the port
   a_r10_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(gnt & req & burst)) && ((req & ~gnt) == '0)) |=> (gnt == $past(gnt)));

   // R6: park mode none releases an idle port
   a_r6_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      ((req == '0) && (park_mode == 2'd0)) |=> (gnt == '0));

endmodule

// File: rtl/busmx_wmux.sv
module busmx_wmux #(
   parameter int unsigned N_MST = 6,
   parameter int unsigned DW    = 8
) (
   input  logic [N_MST-1:0]    gnt,
   input  logic [N_MST*DW-1:0] wdata,
   output logic [DW-1:0]       y
);

   // AND-OR select; the grant vector is one-hot or empty
   always_comb begin
      y = '0;
      for (int m = 0; m < N_MST; m++) begin
         y = y | (wdata[m*DW +: DW] & {DW{gnt[m]}});
      end
   end

endmodule

// File: rtl/busmx_arbiter.sv
module busmx_arbiter
   import busmx_pkg::*;
#(
   parameter int unsigned N_MST  = 6,
   parameter int unsigned N_SLV  = 6,
   parameter int unsigned AW     = 16,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned DW     = 8,
   parameter int unsigned LIM_W  = 4,
   parameter int unsigned MIDX_W = idx_w(N_MST)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_MST-1:0]        m_req,
   input  logic [N_MST*AW-1:0]     m_addr,
   input  logic [N_MST-1:0]        m_burst,
   input  logic [N_MST*DW-1:0]     m_wdata,
   input  logic [2*N_SLV-1:0]      cfg_park_mode,
   input  logic [MIDX_W*N_SLV-1:0] cfg_park_mst,
   input  logic [LIM_W*N_SLV-1:0]  cfg_slot_lim,
   output logic [N_SLV*N_MST-1:0]  s_gnt,
   output logic [N_SLV*DW-1:0]     s_wdata,
   output logic [N_MST-1:0]        m_ready,
   output logic [N_MST-1:0]        m_dec_err
);

   initial begin
      assert (N_MST >= 1 && N_MST <= 32)
         else $error("busmx_arbiter: N_MST out of range");
      assert (N_SLV >= 1 && N_SLV <= (1 << SEL_W))
         else $error("busmx_arbiter: N_SLV does not fit the address code");
      assert (DW >= 1 && AW >= SEL_W)
         else $error("busmx_arbiter: bad data or address width");
   end

   logic [N_SLV-1:0] sel_m [N_MST];
   logic [N_MST-1:0] req_s [N_SLV];
   logic [N_MST-1:0] gnt_s [N_SLV];

   genvar gm, gs;

   generate
      for (gm = 0; gm < N_MST; gm++) begin : g_mst
         busmx_decoder #(.AW(AW), .SEL_W(SEL_W), .N_SLV(N_SLV)) dec_i (
            .req  (m_req[gm]),
            .addr (m_addr[gm*AW +: AW]),
            .sel  (sel_m[gm]),
            .err  (m_dec_err[gm])
         );

         // R2: an unmapped request is never accepted
         a_r2_err_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
            m_dec_err[gm] |-> !m_ready[gm]);
      end

      for (gs = 0; gs < N_SLV; gs++) begin : g_slv
         for (gm = 0; gm < N_MST; gm++) begin : g_xp
            assign req_s[gs][gm] = sel_m[gm][gs];
         end

         busmx_port_arb #(.N_MST(N_MST), .LIM_W(LIM_W), .MIDX_W(MIDX_W)) arb_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_s[gs]),
            .burst     (m_burst),
            .park_mode (cfg_park_mode[2*gs +: 2]),
            .park_mst  (cfg_park_mst[MIDX_W*gs +: MIDX_W]),
            .slot_lim  (cfg_slot_lim[LIM_W*gs +: LIM_W]),
            .gnt       (gnt_s[gs])
         );

         busmx_wmux #(.N_MST(N_MST), .DW(DW)) mux_i (
            .gnt   (gnt_s[gs]),
            .wdata (m_wdata),
            .y     (s_wdata[gs*DW +: DW])
         );

         assign s_gnt[gs*N_MST +: N_MST] = gnt_s[gs];
      end
   endgenerate

   always_comb begin
      m_ready = '0;
      for (int m = 0; m < N_MST; m++) begin
         for (int s = 0; s < N_SLV; s++) begin
            if (sel_m[m][s] && gnt_s[s][m]) m_ready[m] = 1'b1;
         end
      end
   end

endmodule

// File: tb/busmx_arbiter_tb_top.sv
`timescale 1ns/1ps
module busmx_arbiter_tb_top;

   localparam int NM = 6;
   localparam int NS = 6;
   localparam int AW = 16;
   localparam int SW = 3;
   localparam int DW = 8;
   localparam int LW = 4;
   localparam int MW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NM-1:0]    m_req = '0;
   logic [NM*AW-1:0] m_addr = '0;
   logic [NM-1:0]    m_burst = '0;
   logic [NM*DW-1:0] m_wdata = '0;
   logic [2*NS-1:0]  cfg_park_mode = '0;
   logic [MW*NS-1:0] cfg_park_mst = '0;
   logic [LW*NS-1:0] cfg_slot_lim = '0;
   logic [NS*NM-1:0] s_gnt;
   logic [NS*DW-1:0] s_wdata;
   logic [NM-1:0]    m_ready;
   logic [NM-1:0]    m_dec_err;

   int vec_cnt = 0;
   int mis_cnt = 0;
   string tag = "R3";

   // reference model state
   bit mv [NS];
   int mi [NS];
   int mp [NS];
   int mc [NS];

   always #4 clk = ~clk;

   busmx_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_burst(m_burst),
      .m_wdata(m_wdata), .cfg_park_mode(cfg_park_mode), .cfg_park_mst(cfg_park_mst),
      .cfg_slot_lim(cfg_slot_lim), .s_gnt(s_gnt), .s_wdata(s_wdata),
      .m_ready(m_ready), .m_dec_err(m_dec_err)
   );

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      vec_cnt++;
      if (act !== exp) begin
         mis_cnt++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int code_of(input int m);
      return int'(m_addr[m*AW + AW - SW +: SW]);
   endfunction

   task automatic drive_m(input int m, input bit r, input int code, input bit b, input logic [7:0] wd);
      m_req[m] = r;
      m_addr[m*AW +: AW] = {code[SW-1:0], 13'($urandom)};
      m_burst[m] = b;
      m_wdata[m*DW +: DW] = wd;
   endtask

   task automatic set_cfg(input int s, input int mode, input int pm, input int lim);
      cfg_park_mode[2*s +: 2] = mode[1:0];
      cfg_park_mst[MW*s +: MW] = pm[MW-1:0];
      cfg_slot_lim[LW*s +: LW] = lim[LW-1:0];
   endtask

   task automatic compare();
      logic [NS*NM-1:0] eg;
      logic [NM-1:0] er, ee;
      logic [NS*DW-1:0] ew;
      eg = '0; er = '0; ee = '0; ew = '0;
      for (int s = 0; s < NS; s++) begin
         if (mv[s]) begin
            eg[s*NM + mi[s]] = 1'b1;
            ew[s*DW +: DW] = m_wdata[mi[s]*DW +: DW];
         end
      end
      for (int m = 0; m < NM; m++) begin
         if (m_req[m] && code_of(m) >= NS) ee[m] = 1'b1;
         if (m_req[m] && code_of(m) < NS && mv[code_of(m)] && mi[code_of(m)] == m) er[m] = 1'b1;
      end
      chk(tag, "s_gnt", longint'(s_gnt), longint'(eg));
      chk(tag, "m_ready", longint'(m_ready), longint'(er));
      chk(tag, "m_dec_err", longint'(m_dec_err), longint'(ee));
      chk(tag, "s_wdata", longint'(s_wdata), longint'(ew));
   endtask

   task automatic model_update();
      for (int s = 0; s < NS; s++) begin
         bit rq [NM];
         bit any, oth, exp_b, hld;
         int lim, mode, pm, w;
         lim  = int'(cfg_slot_lim[LW*s +: LW]);
         mode = int'(cfg_park_mode[2*s +: 2]);
         pm   = int'(cfg_park_mst[MW*s +: MW]);
         any = 0; oth = 0;
         for (int m = 0; m < NM; m++) begin
            rq[m] = m_req[m] && (code_of(m) == s);
            if (rq[m]) any = 1;
            if (rq[m] && !(mv[s] && mi[s] == m)) oth = 1;
         end
         exp_b = (lim != 0) && (mc[s] <= 1);
         hld = mv[s] && rq[mi[s]] && m_burst[mi[s]] && !(exp_b && oth);
         if (hld) begin
            if (mc[s] > 0) mc[s]--;
         end else if (any) begin
            w = -1;
            for (int k = 0; k < NM; k++)
               if (w < 0 && rq[(mp[s] + k) % NM]) w = (mp[s] + k) % NM;
            mv[s] = 1; mi[s] = w; mp[s] = (w + 1) % NM; mc[s] = lim;
         end else begin
            mc[s] = lim;
            if (mode == 1) begin
               // keep current owner
            end else if (mode == 2) begin
               if (pm < NM) begin mv[s] = 1; mi[s] = pm; end
               else begin mv[s] = 0; mi[s] = 0; end
            end else begin
               mv[s] = 0; mi[s] = 0;
            end
         end
      end
   endtask

   // inputs already set just after a falling edge
   task automatic tick();
      #1;
      compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, mis_cnt);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      mis_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c2, c5;
      for (int s = 0; s < NS; s++) begin mv[s] = 0; mi[s] = 0; mp[s] = 0; mc[s] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R3: reset state
      chk("R3", "reset s_gnt", longint'(s_gnt), 0);
      chk("R3", "reset m_ready", longint'(m_ready), 0);

      // R1 / R4: master 0 to slave 2, park none
      tag = "R4";
      drive_m(0, 1, 2, 0, 8'hA0);
      #1 chk("R4", "no ready before grant", longint'(m_ready[0]), 0);
      tick();
      chk("R1", "grant at slave 2 only", longint'(s_gnt), longint'(1) << (2*NM + 0));
      chk("R4", "ready next cycle", longint'(m_ready[0]), 1);
      drive_m(0, 0, 2, 0, 8'h00);
      tick();

      // R2: unmapped code 7
      tag = "R2";
      drive_m(1, 1, 7, 0, 8'h11);
      #1 chk("R2", "dec_err", longint'(m_dec_err[1]), 1);
      tick();
      chk("R2", "no grant for unmapped", longint'(s_gnt), 0);
      chk("R2", "no ready for unmapped", longint'(m_ready[1]), 0);
      drive_m(1, 0, 0, 0, 8'h00);
      tick();

      // R7 / R6 / R8 on slave 1
      tag = "R7";
      set_cfg(1, 1, 0, 0);
      drive_m(3, 1, 1, 0, 8'h33);
      tick();
      drive_m(3, 0, 1, 0, 8'h33);
      tick(); tick();
      chk("R7", "last owner kept", longint'(s_gnt[1*NM +: NM]), 6'b001000);
      tag = "R6";
      set_cfg(1, 0, 0, 0);
      tick();
      chk("R6", "park none releases", longint'(s_gnt[1*NM +: NM]), 0);
      tag = "R8";
      set_cfg(1, 2, 4, 0);
      tick();
      chk("R8", "fixed park master 4", longint'(s_gnt[1*NM +: NM]), 6'b010000);
      set_cfg(1, 2, 7, 0);
      tick();
      chk("R8", "fixed index out of range", longint'(s_gnt[1*NM +: NM]), 0);
      set_cfg(1, 3, 0, 0);
      tick();
      chk("R6", "mode 3 acts as none", longint'(s_gnt[1*NM +: NM]), 0);

      // R9: parked master served at once on slave 3
      tag = "R9";
      set_cfg(3, 2, 4, 0);
      tick(); tick();
      drive_m(4, 1, 3, 0, 8'h44);
      #1 chk("R9", "parked master ready same cycle", longint'(m_ready[4]), 1);
      tick();
      drive_m(4, 0, 3, 0, 8'h00);
      tick();

      // R5 / R12 / R13: three non-burst masters on slave 5
      tag = "R5";
      drive_m(0, 1, 5, 0, 8'h10);
      drive_m(1, 1, 5, 0, 8'h11);
      drive_m(2, 1, 5, 0, 8'h12);
      tick();
      chk("R5", "first winner master 0", longint'(m_ready), 6'b000001);
      chk("R13", "wdata from master 0", longint'(s_wdata[5*DW +: DW]), 8'h10);
      tick();
      chk("R12", "non-burst owner yields to master 1", longint'(m_ready), 6'b000010);
      chk("R13", "wdata from master 1", longint'(s_wdata[5*DW +: DW]), 8'h11);
      tick();
      chk("R5", "then master 2", longint'(m_ready), 6'b000100);
      tick();
      chk("R5", "wrap to master 0", longint'(m_ready), 6'b000001);
      m_req = '0;
      tick();
      chk("R13", "wdata zero when idle", longint'(s_wdata[5*DW +: DW]), 0);

      // R11 / R10: bursting masters 2 and 5 on slave 4
      tag = "R11";
      set_cfg(4, 0, 0, 3);
      drive_m(2, 1, 4, 1, 8'h22);
      drive_m(5, 1, 4, 1, 8'h55);
      c2 = 0; c5 = 0;
      for (int i = 0; i < 6; i++) begin
         tick();
         c2 += int'(m_ready[2]);
         c5 += int'(m_ready[5]);
      end
      chk("R11", "owner ready cycles at limit 3", c2, 3);
      chk("R11", "contender served after limit", c5, 3);
      tag = "R10";
      set_cfg(4, 0, 0, 0);
      c2 = 0; c5 = 0;
      for (int i = 0; i < 6; i++) begin
         tick();
         c2 += int'(m_ready[2]);
         c5 += int'(m_ready[5]);
      end
      chk("R10", "limit 0 keeps burst owner", c5, 6);
      chk("R10", "contender waits", c2, 0);
      m_req = '0; m_burst = '0;
      tick();

      // random phase, model compared every cycle
      tag = "R3";
      for (int cyc = 0; cyc < 1500; cyc++) begin
         if (cyc % 100 == 0)
            for (int s = 0; s < NS; s++)
               set_cfg(s, int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                       int'($urandom_range(0, 5)));
         for (int m = 0; m < NM; m++)
            drive_m(m, ($urandom_range(0, 9) < 6), int'($urandom_range(0, 7)),
                    1'($urandom), 8'($urandom));
         tick();
      end
      finish_run();
   end

endmodule